// File: doc/BRIEF.md
# I2C Event Flag and Clock-Stretch Controller

This block sits between the bus-side logic of an I2C controller and the software that services it. The bus interface and the address matcher report bus happenings as one-cycle pulses, one wire per kind of happening. Each pulse comes with the current operating mode (master transmit, master receive or slave) and one qualifier bit. The block turns each reported happening into an 8-bit status code. It raises a sticky attention flag, and one clock later it places the code on the status output. While the flag is up, the block drives a hold request that keeps SCL low. The transfer therefore waits until software has read the status and written the clear strobe.

Happenings that arrive while the flag is already up are not lost. Each kind has a pending slot that keeps its latest code. After every clear, the pending slots are posted one at a time in a fixed priority order. While the flag is down, the status output shows the idle code 8'hF8. Every status code has its three low bits at zero.

Top module: `i2c_evt_stretch`

## Requirements
- R1: After reset, `flag_o` is 0, `scl_hold_o` is 0 and `status_o` is 8'hF8.
- R2: Master-side codes, with `evt_i` bit positions: bit 4 (START sent) gives 8'h08, or 8'h10 when `info_i`=1 (repeated START). Bit 0 (arbitration lost) gives 8'h38. Bit 5 (address byte sent), where `info_i`=1 means NACK received: 8'h18/8'h20 in `mode_i`=0 (master transmit), and 8'h40/8'h48 in `mode_i`=1 (master receive).
- R3: Slave-side and receive codes: bit 2 (own address matched) gives 8'h60. Bit 3 (general call) gives 8'h70. Bit 1 (STOP or repeated START seen while addressed) gives 8'hA0. Bit 6 (data byte received), where `info_i`=1 means NACK returned: 8'h50/8'h58 in modes 0 and 1, and 8'h80/8'h88 in `mode_i`=2 (slave).
- R4: A pulse sampled at a clock edge while the flag is down and nothing is pending sets `flag_o` at the next edge. In that first flagged cycle, `status_o` still reads 8'hF8. The event code appears on `status_o` from the following edge on.
- R5: Whenever `flag_o` is 0, `status_o` reads 8'hF8. Every posted code has bits [2:0] equal to 0.
- R6: `scl_hold_o` equals `flag_o` on every cycle.
- R7: Once set, `flag_o` stays set and `status_o` stays unchanged until a cycle with `clr_i`=1. That cycle's edge drops the flag and returns `status_o` to 8'hF8. A `clr_i` pulse while the flag is down has no effect.
- R8: Events that arrive while the flag is set leave `flag_o` and `status_o` untouched and are held pending. After each clear, the next pending event is posted one edge later. The order is bit 0, then 1, 2, 3, 4, 5, 6 (lowest index first).
- R9: A second pulse of the same kind while that kind is pending replaces its held code with the newer one.
- R10: An event pulsed in the same cycle as `clr_i` is kept and posted after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 7 | One-cycle event pulses, one bit per kind |
| mode_i | input | 2 | Mode context: 0 master transmit, 1 master receive, 2 slave |
| info_i | input | 1 | Qualifier: repeated START or NACK, depending on the event |
| clr_i | input | 1 | Software strobe that clears the flag |
| flag_o | output | 1 | Sticky attention flag |
| status_o | output | 8 | Status code, or 8'hF8 when no information is available |
| scl_hold_o | output | 1 | Request to hold SCL low |

## Verification
The assertions watch several properties on every cycle. They check that a code other than idle only appears while the flag is set. They check that the flag falls only on a clear, and that every clear returns the idle code. They check that the status loads from the held code one edge after the flag rises. They check that the pending grant is never more than one-hot, and that any pulsed event lands in its pending slot. The numeric value of each code for each mode and qualifier, the priority order of draining, the overwrite of a pending slot and the no-effect cases can only be shown by the bench's directed scenarios, which compare against an independent code table.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int NUM_EVT = 7;
  localparam int CODE_W  = 5;
  localparam int STAT_W  = 8;
  localparam int LOW_W   = STAT_W - CODE_W;

  // Event bit positions; lower index means higher posting priority
  localparam int EV_ARB   = 0;
  localparam int EV_STOP  = 1;
  localparam int EV_OWN   = 2;
  localparam int EV_GCALL = 3;
  localparam int EV_START = 4;
  localparam int EV_ADDR  = 5;
  localparam int EV_DRX   = 6;

  typedef enum logic [1:0] {
    MODE_MT  = 2'd0,
    MODE_MR  = 2'd1,
    MODE_SLV = 2'd2,
    MODE_RSV = 2'd3
  } mode_e;

  localparam logic [STAT_W-1:0] ST_IDLE = 8'hF8;

  // Upper status bits for an event kind in a given mode
  function automatic logic [CODE_W-1:0] ev_code(int ev, mode_e m, logic info);
    logic [CODE_W-1:0] c;
    case (ev)
      EV_ARB:   c = 5'd7;
      EV_STOP:  c = 5'd20;
      EV_OWN:   c = 5'd12;
      EV_GCALL: c = 5'd14;
      EV_START: c = info ? 5'd2 : 5'd1;
      EV_ADDR:  c = (m == MODE_MR) ? (info ? 5'd9 : 5'd8)
                                   : (info ? 5'd4 : 5'd3);
      EV_DRX:   c = (m == MODE_SLV) ? (info ? 5'd17 : 5'd16)
                                    : (info ? 5'd11 : 5'd10);
      default:  c = 5'd31;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/i2c_evt_encode.sv
module i2c_evt_encode
  import i2c_evt_pkg::*;
#(
  parameter int N  = NUM_EVT,
  parameter int CW = CODE_W
) (
  input  logic [1:0]           mode_i,
  input  logic                 info_i,
  output logic [N-1:0][CW-1:0] code_o
);
  mode_e mode;
  assign mode = mode_e'(mode_i);

  for (genvar g = 0; g < N; g++) begin : g_enc
    assign code_o[g] = ev_code(g, mode, info_i);
  end
endmodule

// File: rtl/i2c_evt_queue.sv
module i2c_evt_queue #(
  parameter int N  = 7,
  parameter int CW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         evt_i,
  input  logic [N-1:0][CW-1:0] code_i,
  input  logic                 post_en_i,
  output logic                 post_valid_o,
  output logic [CW-1:0]        post_code_o
);
  logic [N-1:0]         pend_q, pend_d;
  logic [N-1:0][CW-1:0] code_q, code_d;
  logic [N-1:0]         grant;
  logic [N:0]           above;

  // Fixed priority: lowest index wins
  assign above[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_pri
    assign grant[g]   = pend_q[g] & ~above[g];
    assign above[g+1] = above[g] | pend_q[g];
  end

  always_comb begin
    post_code_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) post_code_o = post_code_o | code_q[i];
    end
  end
  assign post_valid_o = |pend_q;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      pend_d[i] = evt_i[i] | (pend_q[i] & ~(post_en_i & grant[i]));
      code_d[i] = evt_i[i] ? code_i[i] : code_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      code_q <= '0;
    end else begin
      pend_q <= pend_d;
      code_q <= code_d;
    end
  end

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R8
  post_has_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_en_i |-> (|pend_q));
  // R10
  evt_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/i2c_evt_flag.sv
module i2c_evt_flag
  import i2c_evt_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int SW = STAT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          post_valid_i,
  input  logic [CW-1:0] post_code_i,
  output logic          post_en_o,
  output logic          flag_o,
  output logic [SW-1:0] status_o
);
  localparam int LW = SW - CW;

  logic          flag_q, flag_d;
  logic          load_q, load_d;
  logic [CW-1:0] hold_q, hold_d;
  logic [SW-1:0] stat_q, stat_d;
  logic          clr_en;

  assign clr_en    = clr_i & flag_q;
  assign post_en_o = ~flag_q & ~clr_i & post_valid_i;

  always_comb begin
    flag_d = flag_q;
    load_d = 1'b0;
    hold_d = hold_q;
    stat_d = stat_q;
    if (clr_en) begin
      flag_d = 1'b0;
      stat_d = ST_IDLE;
    end else if (post_en_o) begin
      flag_d = 1'b1;
      load_d = 1'b1;
      hold_d = post_code_i;
    end else if (load_q) begin
      stat_d = {hold_q, {LW{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      load_q <= 1'b0;
      hold_q <= '0;
      stat_q <= ST_IDLE;
    end else begin
      flag_q <= flag_d;
      load_q <= load_d;
      hold_q <= hold_d;
      stat_q <= stat_d;
    end
  end

  assign flag_o   = flag_q;
  assign status_o = stat_q;

  // R5
  idle_when_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q |-> (stat_q == ST_IDLE));
  // R4
  stat_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_q) && !clr_i) |=> (stat_q == {$past(hold_q), {LW{1'b0}}}));
  // R4
  first_cycle_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (stat_q == ST_IDLE));
  // R7
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);
  // R7
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && clr_i) |=> (!flag_q && stat_q == ST_IDLE));
endmodule

// File: rtl/i2c_evt_stretch.sv
module i2c_evt_stretch
  import i2c_evt_pkg::*;
#(
  parameter int N  = NUM_EVT,
  parameter int CW = CODE_W,
  parameter int SW = STAT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  evt_i,
  input  logic [1:0]    mode_i,
  input  logic          info_i,
  input  logic          clr_i,
  output logic          flag_o,
  output logic [SW-1:0] status_o,
  output logic          scl_hold_o
);
  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic [N-1:0][CW-1:0] ev_codes;
  logic                 post_en, post_valid;
  logic [CW-1:0]        post_code;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  i2c_evt_encode #(.N(N), .CW(CW)) u_enc (
    .mode_i (mode_i),
    .info_i (info_i),
    .code_o (ev_codes)
  );

  i2c_evt_queue #(.N(N), .CW(CW)) u_queue (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .evt_i        (evt_i),
    .code_i       (ev_codes),
    .post_en_i    (post_en),
    .post_valid_o (post_valid),
    .post_code_o  (post_code)
  );

  i2c_evt_flag #(.CW(CW), .SW(SW)) u_flag (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .clr_i        (clr_i),
    .post_valid_i (post_valid),
    .post_code_i  (post_code),
    .post_en_o    (post_en),
    .flag_o       (flag_o),
    .status_o     (status_o)
  );

  assign scl_hold_o = flag_o;
endmodule

// File: tb/test_i2c_evt_stretch.sv
module test_i2c_evt_stretch;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] evt;
  logic [1:0] mode;
  logic       info;
  logic       clr;
  logic       flag, hold;
  logic [7:0] stat;
  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  i2c_evt_stretch i_i2c_evt_stretch (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .mode_i(mode), .info_i(info),
    .clr_i(clr), .flag_o(flag), .status_o(stat), .scl_hold_o(hold)
  );

  function automatic logic [7:0] exp_code(int ev, int m, logic inf);
    case (ev)
      0: return 8'h38;
      1: return 8'hA0;
      2: return 8'h60;
      3: return 8'h70;
      4: return inf ? 8'h10 : 8'h08;
      5: return (m == 1) ? (inf ? 8'h48 : 8'h40) : (inf ? 8'h20 : 8'h18);
      default: return (m == 2) ? (inf ? 8'h88 : 8'h80) : (inf ? 8'h58 : 8'h50);
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Flag just set: idle code, hold tracks flag
  task automatic chk_first(string req);
    chk(req, {7'd0, flag}, 8'd1);
    chk({req, " R6"}, {7'd0, hold}, {7'd0, flag});
    chk({req, " R4 first cycle"}, stat, 8'hF8);
  endtask

  task automatic pulse(logic [6:0] e, int m, logic inf);
    @(negedge clk); evt = e; mode = m[1:0]; info = inf;
    @(negedge clk); evt = '0; info = 1'b0;
  endtask

  task automatic clear_flag(string req);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk({req, " R7 cleared"}, {7'd0, flag}, 8'd0);
    chk({req, " R5 idle"}, stat, 8'hF8);
    chk({req, " R6"}, {7'd0, hold}, 8'd0);
  endtask

  task automatic expect_post(string req, logic [7:0] code);
    @(negedge clk); chk_first(req);
    @(negedge clk); chk({req, " code"}, stat, code);
    chk({req, " R5 low bits"}, {5'd0, stat[2:0]}, 8'd0);
  endtask

  task automatic one_event(string req, int ev, int m, logic inf);
    pulse(7'(1 << ev), m, inf);
    @(negedge clk); chk_first(req);
    @(negedge clk); chk({req, " code"}, stat, exp_code(ev, m, inf));
    clear_flag(req);
  endtask

  task automatic t_reset();
    chk("R1 flag", {7'd0, flag}, 8'd0);
    chk("R1 hold", {7'd0, hold}, 8'd0);
    chk("R1 status", stat, 8'hF8);
  endtask

  task automatic t_master_codes();
    one_event("R2 start", 4, 0, 1'b0);
    one_event("R2 rep start", 4, 0, 1'b1);
    one_event("R2 arb lost", 0, 0, 1'b0);
    one_event("R2 addr MT ack", 5, 0, 1'b0);
    one_event("R2 addr MT nack", 5, 0, 1'b1);
    one_event("R2 addr MR ack", 5, 1, 1'b0);
    one_event("R2 addr MR nack", 5, 1, 1'b1);
  endtask

  task automatic t_slave_codes();
    one_event("R3 own addr", 2, 2, 1'b0);
    one_event("R3 gcall", 3, 2, 1'b0);
    one_event("R3 stop", 1, 2, 1'b0);
    one_event("R3 drx MR ack", 6, 1, 1'b0);
    one_event("R3 drx MR nack", 6, 1, 1'b1);
    one_event("R3 drx slv ack", 6, 2, 1'b0);
    one_event("R3 drx slv nack", 6, 2, 1'b1);
  endtask

  task automatic t_sticky();
    pulse(7'(1 << 2), 2, 1'b0);
    repeat (2) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R7 stays set", {7'd0, flag}, 8'd1);
    chk("R7 status held", stat, 8'h60);
    chk("R6 hold while set", {7'd0, hold}, 8'd1);
    clear_flag("R7 sticky");
    // clear while idle: no effect, nothing posted afterwards
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 idle clr flag", {7'd0, flag}, 8'd0);
    chk("R7 idle clr status", stat, 8'hF8);
  endtask

  task automatic t_priority();
    pulse(7'(1 << 4), 0, 1'b0);
    repeat (2) @(negedge clk);
    pulse(7'b1000011, 2, 1'b0);
    @(negedge clk);
    chk("R8 no disturb flag", {7'd0, flag}, 8'd1);
    chk("R8 no disturb status", stat, 8'h08);
    clear_flag("R8 q0");
    expect_post("R8 first arb", 8'h38);
    clear_flag("R8 q1");
    expect_post("R8 second stop", 8'hA0);
    clear_flag("R8 q2");
    expect_post("R8 third drx", 8'h80);
    clear_flag("R8 q3");
    repeat (2) @(negedge clk);
    chk("R8 drained", {7'd0, flag}, 8'd0);
  endtask

  task automatic t_overwrite();
    pulse(7'(1 << 3), 2, 1'b0);
    repeat (2) @(negedge clk);
    pulse(7'(1 << 6), 1, 1'b0);
    pulse(7'(1 << 6), 1, 1'b1);
    clear_flag("R9 a");
    expect_post("R9 newest code", 8'h58);
    clear_flag("R9 b");
    repeat (2) @(negedge clk);
    chk("R9 single post", {7'd0, flag}, 8'd0);
  endtask

  task automatic t_clr_same_cycle();
    pulse(7'(1 << 0), 0, 1'b0);
    repeat (2) @(negedge clk);
    @(negedge clk); clr = 1'b1; evt = 7'(1 << 5); mode = 2'd1; info = 1'b1;
    @(negedge clk); clr = 1'b0; evt = '0; info = 1'b0;
    chk("R10 cleared", {7'd0, flag}, 8'd0);
    expect_post("R10 kept", 8'h48);
    clear_flag("R10 end");
  endtask

  initial begin
    rst_n = 1'b0; evt = '0; mode = '0; info = 1'b0; clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_master_codes();
    t_slave_codes();
    t_sticky();
    t_priority();
    t_overwrite();
    t_clr_same_cycle();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule